// File: doc/BRIEF.md
# Dual-Bank RGB Pixel Capture

This block takes digitised RGB pixels, six bits per colour, on an external pixel clock and spreads them across two storage banks, one pixel at a time. An internal bank pointer picks the even or odd bank for the next pixel. Each bank has its own write enable, and a pixel is stored only when the enable of the bank being pointed at is high. Each bank is an asynchronous FIFO. The read side runs on a separate clock a little faster than half the pixel rate. Whenever both banks hold data, it pops one entry from each and emits a single wide word that carries an even pixel and an odd pixel.

A one-bit composite sync input, already sliced to a logic level, is measured in pixel-clock cycles. A low pulse of medium length counts as a line sync, and a very long one counts as a frame sync. Either kind sends the bank pointer back to the even bank. Either kind also marks the next stored pixel, so the read side can flag the word that starts a line or a frame.

Two pixel formats are supported, chosen by a static mode input. The compact format drops the red and blue least-significant bits to give 5/6/5. The wide format keeps all 18 bits.

Top module: `pixcap_top`

## Requirements
- R1: After both resets, `rd_valid`, `rd_line_start`, `rd_frame_start`, `hs_pulse` and `vs_pulse` are all low.
- R2: A low period of `csync_in` lasting L pixel-clock cycles produces exactly one `hs_pulse` when HS_MIN_CYC ≤ L ≤ HS_MAX_CYC (defaults 50 and 201). It produces exactly one `vs_pulse` when L ≥ VS_MIN_CYC (default 503). Any other length produces neither.
- R3: After reset the bank pointer selects the even bank. On a pixel-clock edge, the pixel is stored if the enable of the selected bank is high, and the pointer then moves to the other bank. The enable of the non-selected bank has no effect.
- R4: A line sync or frame sync sends the pointer back to the even bank, so the first pixel stored afterwards goes to the even bank.
- R5: With `wide_mode`=0, a stored pixel is {r[5:1], g[5:0], b[5:1]}. The word carries the even pixel in bits [15:0], the odd pixel in bits [31:16], and zero in bits [35:32].
- R6: With `wide_mode`=1, a stored pixel is {r, g, b}. The word carries the even pixel in bits [17:0] and the odd pixel in bits [35:18].
- R7: `rd_valid` is high for one read cycle for each even/odd pair popped. Words come out in the order the pixels were stored, and a word appears only when both banks hold data.
- R8: Each bank holds 2^FIFO_AW pixels (16 by default). A pixel that arrives at a full bank is discarded, and the bank keeps its earlier contents.
- R9: `rd_line_start` is high exactly on the word whose even pixel was the first one stored after a line or frame sync.
- R10: `rd_frame_start` is high exactly on the word whose even pixel was the first one stored after a frame sync. `rd_line_start` is also high on that word.
- R11: A 640-pixel line that follows a line sync comes out as 320 words, in order and intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Pixel (write) clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| pix_r | input | 6 | Red sample |
| pix_g | input | 6 | Green sample |
| pix_b | input | 6 | Blue sample |
| we_even | input | 1 | Write enable of the even bank |
| we_odd | input | 1 | Write enable of the odd bank |
| csync_in | input | 1 | Binary composite sync, active low, asynchronous |
| wide_mode | input | 1 | 1 selects 6/6/6 pixels, 0 selects 5/6/5; held static while capturing |
| hs_pulse | output | 1 | One-cycle line-sync detect, write domain |
| vs_pulse | output | 1 | One-cycle frame-sync detect, write domain |
| rd_valid | output | 1 | Word valid, read domain |
| rd_word | output | 36 | Packed even/odd pixel pair |
| rd_line_start | output | 1 | Word opens a line |
| rd_frame_start | output | 1 | Word opens a frame |

## Verification
The bench drives sync pulses of exactly HS_MIN-1, HS_MIN, HS_MAX, HS_MAX+1, a length between the line and frame ranges, and VS_MIN. An off-by-one in the pulse counter would miss a legal line sync or accept a stray glitch as one. Short lines with odd pixel counts are broken by a sync, and cycles are driven with only the wrong bank's enable high. A pointer that does not return to the even bank, or that steps on a rejected pixel, would pair pixels from different lines or shift every word by one pixel. With the read clock stopped, 40 pixels are pushed into a 16-deep bank pair. A full flag that fails to block writes would overwrite stored pixels or report a phantom word once reading resumes. Both pixel formats are checked word by word, together with the line and frame flags, against a queue model in the bench.

// File: rtl/pixcap_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, the bank entry type and pixel formatting.
// Assumes six-bit colour channels from the digitiser.
package pixcap_pkg;
    localparam int COL_W  = 6;
    localparam int PIX_W  = 3 * COL_W;
    localparam int WORD_W = 2 * PIX_W;
    localparam int C565_W = 16;

    typedef struct packed {
        logic             line_first;
        logic             frame_first;
        logic [PIX_W-1:0] pix;
    } cap_entry_t;

    localparam int ENTRY_W = $bits(cap_entry_t);

    // Format one pixel: full 6/6/6, or 5/6/5 right-aligned with zero fill.
    function automatic logic [PIX_W-1:0] fmt_pixel(
        input logic [COL_W-1:0] r,
        input logic [COL_W-1:0] g,
        input logic [COL_W-1:0] b,
        input logic             wide
    );
        logic [PIX_W-1:0] res;
        if (wide)
            res = {r, g, b};
        else
            res = {{(PIX_W-C565_W){1'b0}}, r[COL_W-1:1], g, b[COL_W-1:1]};
        return res;
    endfunction
endpackage

// File: rtl/pixcap_sync_det.sv
`timescale 1ns/1ps
// Sync detector: synchronises the binary composite sync to the pixel clock,
// measures each low period in cycles (saturating) and, on the rising edge,
// classifies it as line sync, frame sync or noise.
// Assumes HS_MIN < HS_MAX < VS_MIN and an idle-high input.
module pixcap_sync_det #(
    parameter int HS_MIN = 50,
    parameter int HS_MAX = 201,
    parameter int VS_MIN = 503
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_raw,
    output logic hs_pulse,
    output logic vs_pulse
);
    localparam int CNT_W = $clog2(VS_MIN + 2);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(VS_MIN);
    localparam logic [CNT_W-1:0] HS_LO   = CNT_W'(HS_MIN);
    localparam logic [CNT_W-1:0] HS_HI   = CNT_W'(HS_MAX);

    logic             sync_s1, sync_s2, sync_prev;
    logic [CNT_W-1:0] low_cnt;
    logic             rise;

    assign rise = sync_s2 && !sync_prev;

    // Synchronise the input, count the low time, classify on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_s1   <= 1'b1;
            sync_s2   <= 1'b1;
            sync_prev <= 1'b1;
            low_cnt   <= '0;
            hs_pulse  <= 1'b0;
            vs_pulse  <= 1'b0;
        end else begin
            sync_s1   <= csync_raw;
            sync_s2   <= sync_s1;
            sync_prev <= sync_s2;
            hs_pulse  <= rise && (low_cnt >= HS_LO) && (low_cnt <= HS_HI);
            vs_pulse  <= rise && (low_cnt >= CNT_SAT);
            if (!sync_s2) begin
                if (low_cnt != CNT_SAT)
                    low_cnt <= low_cnt + 1'b1;
            end else begin
                low_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/pixcap_steer.sv
`timescale 1ns/1ps
// Bank steering: holds the even/odd pointer, accepts a pixel when the
// selected bank's enable is high, formats it and tags the first pixel after
// a line or frame sync. A sync pulse takes priority over a pixel.
// Assumes the pixel bus is valid at every pixel-clock edge.
module pixcap_steer
    import pixcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [COL_W-1:0] pix_r,
    input  logic [COL_W-1:0] pix_g,
    input  logic [COL_W-1:0] pix_b,
    input  logic             we_even,
    input  logic             we_odd,
    input  logic             wide_mode,
    input  logic             hs_pulse,
    input  logic             vs_pulse,
    output logic             push_even,
    output logic             push_odd,
    output logic             bank_sel,
    output cap_entry_t       entry
);
    logic line_pend, frame_pend;
    logic sync_any, accept;

    assign sync_any  = hs_pulse || vs_pulse;
    assign accept    = !sync_any && (bank_sel ? we_odd : we_even);
    assign push_even = accept && !bank_sel;
    assign push_odd  = accept && bank_sel;

    // Build the entry that goes to whichever bank accepts this cycle.
    always_comb begin
        entry.line_first  = line_pend;
        entry.frame_first = frame_pend;
        entry.pix         = fmt_pixel(pix_r, pix_g, pix_b, wide_mode);
    end

    // Pointer and start-of-line/frame tags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_sel   <= 1'b0;
            line_pend  <= 1'b0;
            frame_pend <= 1'b0;
        end else if (sync_any) begin
            bank_sel   <= 1'b0;
            line_pend  <= 1'b1;
            frame_pend <= frame_pend || vs_pulse;
        end else if (accept) begin
            bank_sel   <= !bank_sel;
            line_pend  <= 1'b0;
            frame_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/pixcap_afifo.sv
`timescale 1ns/1ps
// Dual-clock FIFO with Gray-coded pointers and two-flop pointer synchronisers.
// Writes while full are dropped. Read data is the head entry (show-ahead).
// Assumes AW >= 2 and reset applied in both domains together.
module pixcap_afifo #(
    parameter int W  = 20,
    parameter int AW = 4
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic         full,
    input  logic         rclk,
    input  logic         rrst_n,
    input  logic         rd_en,
    output logic [W-1:0] rdata,
    output logic         empty
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wbin, wgray, wbin_nxt, wgray_nxt;
    logic [AW:0]  rbin, rgray, rbin_nxt, rgray_nxt;
    logic [AW:0]  rq1, rq2, wq1, wq2;
    logic         do_wr, do_rd;

    assign do_wr     = wr_en && !full;
    assign do_rd     = rd_en && !empty;
    assign wbin_nxt  = wbin + {{AW{1'b0}}, do_wr};
    assign wgray_nxt = (wbin_nxt >> 1) ^ wbin_nxt;
    assign rbin_nxt  = rbin + {{AW{1'b0}}, do_rd};
    assign rgray_nxt = (rbin_nxt >> 1) ^ rbin_nxt;
    assign rdata     = mem[rbin[AW-1:0]];

    // Storage array write port.
    always_ff @(posedge wclk) begin
        if (do_wr)
            mem[wbin[AW-1:0]] <= wdata;
    end

    // Write pointer, read-pointer synchroniser and full flag.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
            rq1   <= '0;
            rq2   <= '0;
            full  <= 1'b0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= wgray_nxt;
            rq1   <= rgray;
            rq2   <= rq1;
            full  <= (wgray_nxt == {~rq2[AW:AW-1], rq2[AW-2:0]});
        end
    end

    // Read pointer, write-pointer synchroniser and empty flag.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
            wq1   <= '0;
            wq2   <= '0;
            empty <= 1'b1;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= rgray_nxt;
            wq1   <= wgray;
            wq2   <= wq1;
            empty <= (rgray_nxt == wq2);
        end
    end
endmodule

// File: rtl/pixcap_pair.sv
`timescale 1ns/1ps
// Read-side pairing: pops both banks together when each holds a pixel and
// registers one packed word with the start-of-line/frame tags of the even
// pixel. Assumes wide_mode is static while data is in flight.
module pixcap_pair
    import pixcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              ev_empty,
    input  logic              od_empty,
    input  cap_entry_t        ev_head,
    input  cap_entry_t        od_head,
    output logic              pop,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_line_start,
    output logic              rd_frame_start
);
    logic [WORD_W-1:0] packed_word;

    assign pop = !ev_empty && !od_empty;

    // Place the even pixel low and the odd pixel above it.
    always_comb begin
        if (wide_mode)
            packed_word = {od_head.pix, ev_head.pix};
        else
            packed_word = {{(WORD_W-2*C565_W){1'b0}},
                           od_head.pix[C565_W-1:0], ev_head.pix[C565_W-1:0]};
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid       <= 1'b0;
            rd_word        <= '0;
            rd_line_start  <= 1'b0;
            rd_frame_start <= 1'b0;
        end else begin
            rd_valid <= pop;
            if (pop) begin
                rd_word        <= packed_word;
                rd_line_start  <= ev_head.line_first;
                rd_frame_start <= ev_head.frame_first;
            end else begin
                rd_line_start  <= 1'b0;
                rd_frame_start <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pixcap_top.sv
`timescale 1ns/1ps
// Dual-bank RGB pixel capture top: sync detection and bank steering on the
// pixel clock, one dual-clock FIFO per bank, pairing on the read clock.
// Assumes the read clock is faster than half the pixel clock.
module pixcap_top
    import pixcap_pkg::*;
#(
    parameter int HS_MIN_CYC = 50,
    parameter int HS_MAX_CYC = 201,
    parameter int VS_MIN_CYC = 503,
    parameter int FIFO_AW    = 4
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic [COL_W-1:0]  pix_r,
    input  logic [COL_W-1:0]  pix_g,
    input  logic [COL_W-1:0]  pix_b,
    input  logic              we_even,
    input  logic              we_odd,
    input  logic              csync_in,
    input  logic              wide_mode,
    output logic              hs_pulse,
    output logic              vs_pulse,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_line_start,
    output logic              rd_frame_start
);
    localparam int NBANK = 2;

    logic       push_even, push_odd, bank_sel, pop;
    logic       ev_empty, od_empty;
    cap_entry_t entry, ev_head, od_head;
    logic [NBANK-1:0]   bank_push, bank_full, bank_empty;
    logic [ENTRY_W-1:0] bank_head [NBANK];

    pixcap_sync_det #(
        .HS_MIN(HS_MIN_CYC), .HS_MAX(HS_MAX_CYC), .VS_MIN(VS_MIN_CYC)
    ) u_sync (
        .clk(wr_clk), .rst_n(wr_rst_n), .csync_raw(csync_in),
        .hs_pulse(hs_pulse), .vs_pulse(vs_pulse)
    );

    pixcap_steer u_steer (
        .clk(wr_clk), .rst_n(wr_rst_n),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .we_even(we_even), .we_odd(we_odd), .wide_mode(wide_mode),
        .hs_pulse(hs_pulse), .vs_pulse(vs_pulse),
        .push_even(push_even), .push_odd(push_odd),
        .bank_sel(bank_sel), .entry(entry)
    );

    assign bank_push = {push_odd, push_even};

    for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
        pixcap_afifo #(.W(ENTRY_W), .AW(FIFO_AW)) u_fifo (
            .wclk(wr_clk), .wrst_n(wr_rst_n),
            .wr_en(bank_push[gi]), .wdata(entry), .full(bank_full[gi]),
            .rclk(rd_clk), .rrst_n(rd_rst_n),
            .rd_en(pop), .rdata(bank_head[gi]), .empty(bank_empty[gi])
        );
    end

    assign ev_empty = bank_empty[0];
    assign od_empty = bank_empty[1];
    assign ev_head  = cap_entry_t'(bank_head[0]);
    assign od_head  = cap_entry_t'(bank_head[1]);

    pixcap_pair u_pair (
        .clk(rd_clk), .rst_n(rd_rst_n), .wide_mode(wide_mode),
        .ev_empty(ev_empty), .od_empty(od_empty),
        .ev_head(ev_head), .od_head(od_head), .pop(pop),
        .rd_valid(rd_valid), .rd_word(rd_word),
        .rd_line_start(rd_line_start), .rd_frame_start(rd_frame_start)
    );
endmodule

// File: rtl/pixcap_checker.sv
`timescale 1ns/1ps
// Checker: temporal properties of the capture block, bound to the top.
module pixcap_checker (
    input logic wr_clk,
    input logic wr_rst_n,
    input logic rd_clk,
    input logic rd_rst_n,
    input logic hs_pulse,
    input logic vs_pulse,
    input logic push_even,
    input logic push_odd,
    input logic bank_sel,
    input logic ev_empty,
    input logic od_empty,
    input logic rd_valid,
    input logic rd_line_start,
    input logic rd_frame_start
);
    // R2: one low period is never both a line and a frame sync.
    a_r2_sync_exclusive: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !(hs_pulse && vs_pulse));

    // R4: any sync returns the pointer to the even bank.
    a_r4_sel_even_after_sync: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (hs_pulse || vs_pulse) |=> !bank_sel);

    // R3: an even-bank store moves the pointer to the odd bank.
    a_r3_sel_toggles: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        push_even |=> bank_sel);

    // R3: at most one bank is written per pixel.
    a_r3_one_bank: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $onehot0({push_even, push_odd}));

    // R7: a word only follows a cycle where both banks held data.
    a_r7_pop_needs_data: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $rose(rd_valid) |-> $past(!ev_empty && !od_empty));

    // R10: a frame-start word is valid and also a line-start word.
    a_r10_frame_implies_line: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_frame_start |-> (rd_line_start && rd_valid));

    // R9: the line-start flag only appears on a valid word.
    a_r9_line_on_valid: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_line_start |-> rd_valid);
endmodule

bind pixcap_top pixcap_checker u_chk (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .hs_pulse(hs_pulse), .vs_pulse(vs_pulse),
    .push_even(push_even), .push_odd(push_odd), .bank_sel(bank_sel),
    .ev_empty(ev_empty), .od_empty(od_empty),
    .rd_valid(rd_valid), .rd_line_start(rd_line_start),
    .rd_frame_start(rd_frame_start)
);

// File: tb/pixcap_top_bench.sv
`timescale 1ns/1ps
// Directed bench: a queue model of both banks predicts every packed word.
module pixcap_top_bench;
    localparam int HS_MIN = 50;
    localparam int HS_MAX = 201;
    localparam int VS_MIN = 503;
    localparam int AW     = 4;
    localparam int DEPTH  = 1 << AW;

    logic wr_clk = 1'b0, rd_clk = 1'b0, rd_run = 1'b1;
    logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic [5:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic we_even = 1'b0, we_odd = 1'b0, csync_in = 1'b1, wide_mode = 1'b0;
    logic hs_pulse, vs_pulse, rd_valid, rd_line_start, rd_frame_start;
    logic [35:0] rd_word;

    always #5 wr_clk = ~wr_clk;
    always begin
        #9.5;
        if (rd_run || rd_clk) rd_clk = ~rd_clk;
    end

    pixcap_top #(.HS_MIN_CYC(HS_MIN), .HS_MAX_CYC(HS_MAX),
                 .VS_MIN_CYC(VS_MIN), .FIFO_AW(AW)) u_pixcap_top (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .we_even(we_even), .we_odd(we_odd), .csync_in(csync_in), .wide_mode(wide_mode),
        .hs_pulse(hs_pulse), .vs_pulse(vs_pulse), .rd_valid(rd_valid),
        .rd_word(rd_word), .rd_line_start(rd_line_start), .rd_frame_start(rd_frame_start)
    );

    int total = 0, bad = 0, hs_cnt = 0, vs_cnt = 0;
    bit done = 1'b0;
    logic [19:0] mq_e[$], mq_o[$];
    bit msel = 0, mline = 0, mframe = 0, mlimit = 0;
    logic [37:0] cap[$];

    always @(negedge wr_clk) begin
        if (hs_pulse) hs_cnt++;
        if (vs_pulse) vs_cnt++;
    end
    always @(negedge rd_clk)
        if (rd_rst_n && rd_valid) cap.push_back({rd_line_start, rd_frame_start, rd_word});

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [37:0] act, input logic [37:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [17:0] fmt(input logic [5:0] r, g, b, input bit wide);
        return wide ? {r, g, b} : {2'b00, r[5:1], g, b[5:1]};
    endfunction

    task automatic drive(input logic [5:0] r, g, b, input bit ee, input bit eo);
        logic [19:0] ent;
        @(negedge wr_clk);
        pix_r = r; pix_g = g; pix_b = b; we_even = ee; we_odd = eo;
        if (msel ? eo : ee) begin
            ent = {mline, mframe, fmt(r, g, b, wide_mode)};
            if (!msel) begin
                if (!mlimit || mq_e.size() < DEPTH) mq_e.push_back(ent);
            end else begin
                if (!mlimit || mq_o.size() < DEPTH) mq_o.push_back(ent);
            end
            msel = ~msel; mline = 0; mframe = 0;
        end
    endtask

    task automatic pix(input int i);
        logic [5:0] r, g, b;
        r = 6'(i); g = 6'(i) ^ 6'h15; b = 6'(i >> 4) ^ 6'h2a;
        drive(r, g, b, !msel, msel);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge wr_clk);
            we_even = 0; we_odd = 0;
        end
    endtask

    // kind: 0 noise, 1 line sync, 2 frame sync
    task automatic sync_pulse(input int len, input int kind);
        int h0, v0;
        h0 = hs_cnt; v0 = vs_cnt;
        @(negedge wr_clk); csync_in = 0; we_even = 0; we_odd = 0;
        repeat (len - 1) @(negedge wr_clk);
        @(negedge wr_clk); csync_in = 1;
        idle(12);
        chk(hs_cnt - h0 == (kind == 1 ? 1 : 0), "R2", $sformatf("hs count len=%0d", len),
            38'(hs_cnt - h0), 38'(kind == 1 ? 1 : 0));
        chk(vs_cnt - v0 == (kind == 2 ? 1 : 0), "R2", $sformatf("vs count len=%0d", len),
            38'(vs_cnt - v0), 38'(kind == 2 ? 1 : 0));
        if (kind != 0) begin
            msel = 0; mline = 1;
            if (kind == 2) mframe = 1;
        end
    endtask

    task automatic drain_check(input string req);
        logic [19:0] e, o;
        logic [35:0] w;
        logic [37:0] exp, act;
        idle(80);
        while (mq_e.size() > 0 && mq_o.size() > 0) begin
            e = mq_e.pop_front(); o = mq_o.pop_front();
            w = wide_mode ? {o[17:0], e[17:0]} : {4'h0, o[15:0], e[15:0]};
            exp = {e[19], e[18], w};
            if (cap.size() == 0) chk(0, req, "missing word", '0, exp);
            else begin
                act = cap.pop_front();
                chk(act == exp, req, "word/flags", act, exp);
            end
        end
        chk(cap.size() == 0, req, "extra words", 38'(cap.size()), '0);
        cap.delete();
    endtask

    task automatic t_reset();
        repeat (6) @(negedge wr_clk);
        wr_rst_n = 1; rd_rst_n = 1;
        repeat (3) @(negedge wr_clk);
        chk({rd_valid, rd_line_start, rd_frame_start, hs_pulse, vs_pulse} == 5'b0,
            "R1", "outputs after reset",
            38'({rd_valid, rd_line_start, rd_frame_start, hs_pulse, vs_pulse}), '0);
    endtask

    task automatic t_sync();
        sync_pulse(HS_MIN - 1, 0);
        sync_pulse(HS_MIN, 1);
        sync_pulse(HS_MAX, 1);
        sync_pulse(HS_MAX + 1, 0);
        sync_pulse(400, 0);
        sync_pulse(VS_MIN, 2);
    endtask

    task automatic t_line565();   // R5, R9, R11
        sync_pulse(100, 1);
        for (int i = 0; i < 640; i++) pix(i);
        drain_check("R11");
    endtask

    task automatic t_frame();     // R10
        sync_pulse(600, 2);
        for (int i = 0; i < 20; i++) pix(i + 7);
        drain_check("R10");
    endtask

    task automatic t_gate();      // R3: only the selected bank's enable counts
        for (int i = 0; i < 10; i++) begin
            drive(6'(i), 6'(3 * i), 6'h3f, 0, 0);
            drive(6'h3f, 6'h3f, 6'h3f, msel, !msel);
            pix(i + 100);
        end
        drain_check("R3");
    endtask

    task automatic t_full();      // R8
        idle(20);
        rd_run = 0;
        idle(6);
        mlimit = 1;
        for (int i = 0; i < 40; i++) pix(i + 200);
        idle(10);
        mlimit = 0;
        rd_run = 1;
        chk(mq_e.size() == DEPTH && mq_o.size() == DEPTH, "R8", "model depth",
            38'(mq_e.size()), 38'(DEPTH));
        drain_check("R8");
    endtask

    task automatic t_wide();      // R6
        idle(20);
        wide_mode = 1;
        sync_pulse(80, 1);
        for (int i = 0; i < 40; i++) pix(i * 5 + 3);
        drain_check("R6");
        wide_mode = 0;
    endtask

    task automatic t_sel_reset(); // R4, R9
        sync_pulse(80, 1);
        for (int i = 0; i < 3; i++) pix(i + 300);
        sync_pulse(80, 1);
        for (int i = 0; i < 9; i++) pix(i + 400);
        sync_pulse(80, 1);
        for (int i = 0; i < 4; i++) pix(i + 500);
        drain_check("R4");
    endtask

    initial begin
        t_reset();
        t_sync();
        t_line565();
        t_frame();
        t_gate();
        t_full();
        t_wide();
        t_sel_reset();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule